// File: doc/BRIEF.md
# Handshaked LED Toggle Engine

This block wraps a one-shot function core that acts like a compiled software routine under a start, done, idle and ready handshake. Each run of the core walks an index from zero to the interval limit minus one. In the second-to-last step it writes the inverse of a 1-bit input, captured when the run was accepted, to a 1-bit output register. In the same cycle as that write it raises a one-cycle output-valid strobe.

The wrapper around the core converts an active-low board reset into the core's active-high synchronous reset. It waits a short settle time, then holds start and input-valid high for good. Each strobed output is registered back as the next input. The LED therefore flips once per run, and the only copy of its value is the register passed between runs. With the default interval of 100,000,000 cycles at 100 MHz, one run takes about one second.

Top module: `ledBlinkTop`

## Requirements
- R1: While `rstN` is low at a clock edge, the next cycle shows `ledOut`=0, `ledStrobe`=0, `runDone`=0 and `runIdle`=1.
- R2: Counting the first rising edge with `rstN` high as edge 1, the core stays idle through edge 3 and accepts its first run at edge 4, so `runIdle` is low after edge 4.
- R3: With start held, each run keeps `runIdle` low for `CNT_MAX` cycles, followed by one idle cycle in which the next run is accepted. Runs repeat every `CNT_MAX`+1 cycles.
- R4: The output register is written only at the end of the step whose index is `CNT_MAX`-2. The first write therefore lands at edge `CNT_MAX`+3.
- R5: The written value is the inverse of the captured input. Through the feedback path, successive writes give 1, 0, 1, 0 and so on.
- R6: `ledStrobe` is high for exactly one cycle per run, in the cycle right after the output register was updated, and at no other time.
- R7: `runDone` is high for exactly the final step of each run, the same cycle as `ledStrobe`. `runIdle` is low during that step and high in the cycle after.
- R8: `ledOut` holds its value between writes.
- R9: The block works with the smallest legal interval, `CNT_MAX`=3. Smaller values are rejected at elaboration.
- R10: Pulling `rstN` low in the middle of a run returns all outputs to the R1 state. After release, the sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, sampled synchronously |
| ledOut | output | 1 | LED drive; output register of the core |
| ledStrobe | output | 1 | Output-valid strobe of the core |
| runIdle | output | 1 | Core is idle (no run in progress) |
| runDone | output | 1 | Core is on the final step of a run |

## Verification
The bench builds two copies of the block. One uses `CNT_MAX`=20, which puts several full runs, the settle delay and the toggle index within a few hundred cycles. The other uses `CNT_MAX`=3, where the write step, the final step and the restart cycle sit back to back. A reset is applied while the first copy is mid-run and the LED is high, so the recovery and restart sequence is also observed.

// File: rtl/ledTogglePkg.sv
`timescale 1ns/1ps
package ledTogglePkg;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic capture;   // latch the input bit (run accepted)
    logic clearIdx;  // reset the loop index to zero
    logic stepIdx;   // advance the loop index
    logic writeOut;  // update the output register with the inverted input
  } togStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } togState_e;

endpackage

// File: rtl/toggleDatapath.sv
`timescale 1ns/1ps
module toggleDatapath
  import ledTogglePkg::*;
#(
  parameter int CNT_MAX = 100000000,
  parameter int IDX_W   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  togStrobes_t strb,
  input  logic        dinVld,
  input  logic        din,
  output logic        idxAtFlag,
  output logic        idxAtLast,
  output logic        dout,
  output logic        doutVld
);

  localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(CNT_MAX - 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CNT_MAX - 1);

  logic [IDX_W-1:0] loopIdx;
  logic             inReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      loopIdx <= '0;
    end else if (strb.clearIdx) begin
      loopIdx <= '0;
    end else if (strb.stepIdx) begin
      loopIdx <= loopIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inReg <= 1'b0;
    end else if (strb.capture && dinVld) begin
      inReg <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      doutVld <= 1'b0;
    end else begin
      doutVld <= strb.writeOut;
      if (strb.writeOut) begin
        dout <= ~inReg;
      end
    end
  end

  assign idxAtFlag = (loopIdx == FLAG_IDX);
  assign idxAtLast = (loopIdx == LAST_IDX);

endmodule

// File: rtl/toggleControl.sv
`timescale 1ns/1ps
module toggleControl
  import ledTogglePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        idxAtFlag,
  input  logic        idxAtLast,
  output togStrobes_t strb,
  output logic        done,
  output logic        idle,
  output logic        ready
);

  togState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  always_comb begin
    strb     = '0;
    done     = 1'b0;
    ready    = 1'b0;
    idle     = (state == ST_IDLE);
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture  = 1'b1;
          strb.clearIdx = 1'b1;
          stateNxt      = ST_BUSY;
        end
      end
      ST_BUSY: begin
        strb.stepIdx  = 1'b1;
        strb.writeOut = idxAtFlag;
        if (idxAtLast) begin
          done     = 1'b1;
          ready    = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ledBlinkTop.sv
`timescale 1ns/1ps
module ledBlinkTop
  import ledTogglePkg::*;
#(
  parameter int CNT_MAX = 100000000,
  parameter int IDX_W   = 32,
  parameter int DELAY_W = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic ledOut,
  output logic ledStrobe,
  output logic runIdle,
  output logic runDone
);

  if (CNT_MAX < 3) begin : g_badCnt
    $error("ledBlinkTop: CNT_MAX must be at least 3");
  end

  logic               rst;
  logic [DELAY_W-1:0] delayCnt;
  logic               startReq;
  logic               dinVldReg;
  logic               ledIn;
  logic               coreReady;
  logic               idxAtFlag;
  logic               idxAtLast;
  logic               doutBit;
  logic               doutVld;
  togStrobes_t        strb;

  assign rst = ~rstN;

  // Settle counter: runs until its top bit is set, then freezes.
  always_ff @(posedge clk) begin
    if (rst) begin
      delayCnt <= '0;
    end else if (!delayCnt[DELAY_W-1]) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startReq  <= 1'b0;
      dinVldReg <= 1'b0;
    end else if (delayCnt[DELAY_W-1]) begin
      startReq  <= 1'b1;
      dinVldReg <= 1'b1;
    end
  end

  // Feedback: each valid result becomes the next run's input.
  always_ff @(posedge clk) begin
    if (rst) begin
      ledIn <= 1'b0;
    end else if (doutVld) begin
      ledIn <= doutBit;
    end
  end

  toggleControl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (startReq),
    .idxAtFlag (idxAtFlag),
    .idxAtLast (idxAtLast),
    .strb      (strb),
    .done      (runDone),
    .idle      (runIdle),
    .ready     (coreReady)
  );

  toggleDatapath #(
    .CNT_MAX (CNT_MAX),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .dinVld    (dinVldReg),
    .din       (ledIn),
    .idxAtFlag (idxAtFlag),
    .idxAtLast (idxAtLast),
    .dout      (doutBit),
    .doutVld   (doutVld)
  );

  assign ledOut    = doutBit;
  assign ledStrobe = doutVld;

endmodule

// File: rtl/ledBlinkChecker.sv
`timescale 1ns/1ps
module ledBlinkChecker (
  input logic clk,
  input logic rstN,
  input logic ledOut,
  input logic ledStrobe,
  input logic runIdle,
  input logic runDone,
  input logic coreReady
);

  // R6: the strobe never lasts two cycles
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    ledStrobe |=> !ledStrobe);

  // R8: the LED moves only when the strobe marks a write
  a_r8_led_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ledOut) |-> ledStrobe);

  // R5: every write flips the LED
  a_r5_toggle_inverts: assert property (@(posedge clk) disable iff (!rstN)
    ledStrobe |-> (ledOut != $past(ledOut)));

  // R7: the final step coincides with the strobe
  a_r7_done_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> ledStrobe);

  // R7: the core is idle right after the final step
  a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    runDone |=> runIdle);

  // R7: idle and done never overlap
  a_r7_idle_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(runIdle && runDone));

  // R3: ready is followed by the accept cycle
  a_r3_ready_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    coreReady |=> runIdle);

endmodule

bind ledBlinkTop ledBlinkChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ledOut    (ledOut),
  .ledStrobe (ledStrobe),
  .runIdle   (runIdle),
  .runDone   (runDone),
  .coreReady (coreReady)
);

// File: tb/ledBlinkTop_tb.sv
`timescale 1ns/1ps
module ledBlinkTop_tb;

  localparam int CNT_A  = 20;
  localparam int CNT_B  = 3;
  localparam int PHASE1 = 3 * (CNT_A + 1) + 10;  // ends mid-run with LED high
  localparam int PHASE2 = 4 * (CNT_A + 1) + 6;

  typedef struct {
    int   cyc;
    logic val;
  } evt_t;

  logic clk = 1'b0;
  logic rstN;
  logic ledA, strbA, idleA, doneA;
  logic ledB, strbB, idleB, doneB;
  int   cyc;
  int   nChecks;
  int   nFails;
  bit   monOn;
  evt_t expQ[$];

  always #2.5 clk = ~clk;

  ledBlinkTop #(.CNT_MAX(CNT_A)) u_dut (
    .clk(clk), .rstN(rstN), .ledOut(ledA), .ledStrobe(strbA),
    .runIdle(idleA), .runDone(doneA)
  );

  ledBlinkTop #(.CNT_MAX(CNT_B)) u_dutMin (
    .clk(clk), .rstN(rstN), .ledOut(ledB), .ledStrobe(strbB),
    .runIdle(idleB), .runDone(doneB)
  );

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Predictors derived from the requirements.
  function automatic logic pIdle(input int c, input int n);
    return (c < 4) || ((c - 4) % (n + 1) == n);
  endfunction

  function automatic logic pDone(input int c, input int n);
    return (c >= 4) && ((c - 4) % (n + 1) == n - 1);
  endfunction

  function automatic logic pLed(input int c, input int n);
    int writes;
    writes = (c < n + 3) ? 0 : ((c - (n + 3)) / (n + 1) + 1);
    return logic'(writes % 2);
  endfunction

  // Monitor: per-cycle prediction plus scoreboard of strobe events.
  always @(negedge clk) begin
    if (rstN && monOn) begin
      chk("R2 R3 idle (CNT 20)", idleA, pIdle(cyc, CNT_A));
      chk("R7 done (CNT 20)", doneA, pDone(cyc, CNT_A));
      chk("R8 led level (CNT 20)", ledA, pLed(cyc, CNT_A));
      chk("R9 idle (CNT 3)", idleB, pIdle(cyc, CNT_B));
      chk("R9 done (CNT 3)", doneB, pDone(cyc, CNT_B));
      chk("R9 led level (CNT 3)", ledB, pLed(cyc, CNT_B));
      chk("R9 strobe (CNT 3)", strbB, pDone(cyc, CNT_B));
      if (strbA) begin
        if (expQ.size() == 0) begin
          chkInt("R6 unexpected strobe", 1, 0);
        end else begin
          evt_t e;
          e = expQ.pop_front();
          chkInt("R4 strobe cycle", cyc, e.cyc);
          chk("R5 written value", ledA, e.val);
        end
      end
    end
  end

  task automatic checkReset(input string tag);
    chk({tag, " led A"}, ledA, 1'b0);
    chk({tag, " strobe A"}, strbA, 1'b0);
    chk({tag, " idle A"}, idleA, 1'b1);
    chk({tag, " done A"}, doneA, 1'b0);
    chk({tag, " led B"}, ledB, 1'b0);
    chk({tag, " idle B"}, idleB, 1'b1);
  endtask

  // Driver: queue expected strobe events, release reset, run n edges.
  task automatic runPhase(input int n);
    expQ.delete();
    for (int k = 0; (CNT_A + 3) + k * (CNT_A + 1) < n; k++) begin
      evt_t e;
      e.cyc = (CNT_A + 3) + k * (CNT_A + 1);
      e.val = (k % 2 == 0) ? 1'b1 : 1'b0;
      expQ.push_back(e);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
    monOn = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    chkInt("R6 every expected strobe seen", expQ.size(), 0);
  endtask

  initial begin
    rstN    = 1'b0;
    monOn   = 1'b0;
    nChecks = 0;
    nFails  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkReset("R1");

    runPhase(PHASE1);
    chk("R10 LED high before mid-run reset", ledA, 1'b1);
    chk("R10 busy before mid-run reset", idleA, 1'b0);
    rstN  = 1'b0;
    monOn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkReset("R10");

    runPhase(PHASE2);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule